// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO

This block carries data words from a processor core's clock domain into a shared interface clock domain. The two clocks may sit at any phase relative to each other and may run at different rates. Either rate may also be retuned at run time for power management. In normal operation the write and read pointers cross between the domains as Gray codes through a short synchronizer chain. This keeps the crossing safe while adding only a few cycles of latency.

For deterministic runs on a tester, a static mode input puts the FIFO into synchronous operation. In this mode both sides are fed the same clock. The synchronizers are bypassed and the flags are computed straight from the binary pointers, so a word written in one cycle can be read in the next, and every run is cycle-exact. The mode input may change only while both side resets are held low.

The write side offers a valid request and returns a full flag. The read side offers a read request and returns an empty flag, with the oldest stored word always presented on the read data output.

Top module: `dmcx_fifo`

## Requirements
- R1: After both resets are released, `wr_full` is 0 and `rd_empty` is 1.
- R2: In synchronous mode, after a word is accepted at a write clock edge, `rd_empty` is 0 from that edge on, so the word can be read on the next edge.
- R3: In synchronous mode, `wr_full` rises directly after the edge that stores the eighth unread word (default depth 8).
- R4: A write request made while `wr_full` is 1 stores nothing and leaves the write pointer unchanged.
- R5: A read request made while `rd_empty` is 1 removes nothing and leaves the read pointer unchanged.
- R6: Words leave in the order they were accepted. Whenever `rd_empty` is 0, `rd_data` shows the oldest unread word without any read request.
- R7: A read and a write in the same cycle both take effect when the FIFO is neither full nor empty. At full only the read takes effect, and at empty only the write takes effect.
- R8: In either mode `wr_full` is 1 whenever the FIFO holds as many words as its depth, and `rd_empty` is 1 whenever it holds none; the flags are never falsely clear.
- R9: In asynchronous mode, data arrive intact and in order while the read clock's frequency is changed between transfers.
- R10: Each Gray-coded pointer that crosses a domain changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Core-side (write) clock |
| wr_rst_n | input | 1 | Write-side synchronous active-low reset |
| wr_valid | input | 1 | Write request; the word is taken if `wr_full` is 0 |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | FIFO has no free entry as seen from the write side |
| rd_clk | input | 1 | Interface-side (read) clock |
| rd_rst_n | input | 1 | Read-side synchronous active-low reset |
| rd_valid | input | 1 | Read request; the oldest word is removed if `rd_empty` is 0 |
| rd_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | No word is visible to the read side |
| sync_mode | input | 1 | 1 = synchronous (shared clock, synchronizers bypassed), 0 = asynchronous; static outside reset |

## Verification
A push and a pop can land on the same edge. The interesting cases are when the FIFO is exactly full or exactly empty, where one of the two must be refused. In synchronous mode the bench steers the occupancy to 1, to the full depth and to 0, then raises both requests together. Each cycle's flags and head word are compared with a queue model that first applies only the accepted operations. In asynchronous mode both sides run freely on unrelated clocks, so pushes and pops overlap in arbitrary alignment. There the model requires the flags to be asserted whenever the true occupancy demands it, and requires every popped word to match the queue head.

// File: rtl/dmcx_pkg.sv
// Shared definitions for the dual-mode clock-crossing FIFO.
package dmcx_pkg;

    // Operating mode carried on the sync_mode pin.
    typedef enum logic {
        XMODE_ASYNC = 1'b0,
        XMODE_SYNC  = 1'b1
    } xmode_e;

    // Binary to reflected Gray code, up to 32 bits; callers cast to width.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/dmcx_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer bus.
// Assumes the input changes in at most one bit per source clock, so every
// captured value is either the old or the new pointer.
module dmcx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            // First capture flop, fed from the other domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= d;
            end
        end else begin : g_next
            // Later flops let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dmcx_wr_ctrl.sv
// Write-side pointer and full flag.
// Asynchronous mode compares the Gray pointer against the synchronized read
// Gray pointer. Synchronous mode compares binary pointers directly and
// assumes both sides share one clock. Needs AW >= 2.
module dmcx_wr_ctrl
    import dmcx_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_mode,
    input  logic        push_req,
    input  logic [AW:0] peer_gray,
    input  logic [AW:0] peer_bin,
    output logic [AW:0] bin,
    output logic [AW:0] gray,
    output logic        full,
    output logic        push,
    output logic [AW-1:0] addr
);
    localparam int PW = AW + 1;
    logic [PW-1:0] bin_nx;

    assign push   = push_req && !full;
    assign bin_nx = bin + PW'(push);
    assign addr   = bin[AW-1:0];

    // Advance the binary and Gray copies of the write pointer together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= PW'(bin_to_gray(32'(bin_nx)));
        end
    end

    // Full when the pointers differ only in the wrap bit (Gray: top two bits).
    always_comb begin
        if (xmode_e'(sync_mode) == XMODE_SYNC)
            full = (bin == {~peer_bin[AW], peer_bin[AW-1:0]});
        else
            full = (gray == {~peer_gray[AW:AW-1], peer_gray[AW-2:0]});
    end
endmodule

// File: rtl/dmcx_rd_ctrl.sv
// Read-side pointer and empty flag.
// Asynchronous mode compares against the synchronized write Gray pointer.
// Synchronous mode compares raw binary pointers of a shared clock.
module dmcx_rd_ctrl
    import dmcx_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_mode,
    input  logic        pop_req,
    input  logic [AW:0] peer_gray,
    input  logic [AW:0] peer_bin,
    output logic [AW:0] bin,
    output logic [AW:0] gray,
    output logic        empty,
    output logic [AW-1:0] addr
);
    localparam int PW = AW + 1;
    logic          pop;
    logic [PW-1:0] bin_nx;

    assign pop    = pop_req && !empty;
    assign bin_nx = bin + PW'(pop);
    assign addr   = bin[AW-1:0];

    // Advance the binary and Gray copies of the read pointer together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= PW'(bin_to_gray(32'(bin_nx)));
        end
    end

    // Empty when the read pointer has caught up with the visible write pointer.
    always_comb begin
        if (xmode_e'(sync_mode) == XMODE_SYNC)
            empty = (bin == peer_bin);
        else
            empty = (gray == peer_gray);
    end
endmodule

// File: rtl/dmcx_ram.sv
// Storage array: written on the write clock, read combinationally so the
// head word is always presented. Assumes the controls never write a slot
// that is still unread.
module dmcx_ram #(
    parameter int DW = 64,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmcx_fifo.sv
// Dual-mode clock-crossing FIFO, top level.
// Joins the two pointer controls, the two synchronizers and the storage.
// sync_mode must be static while either reset is released. In synchronous
// mode both clock pins must carry the same clock.
module dmcx_fifo #(
    parameter int DATA_W      = 64,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    input  logic              sync_mode
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0]     rd_gray_at_wr, wr_gray_at_rd;
    logic              wr_push;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    dmcx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_at_wr)
    );

    dmcx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_at_rd)
    );

    dmcx_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .sync_mode(sync_mode),
        .push_req(wr_valid), .peer_gray(rd_gray_at_wr), .peer_bin(rd_bin),
        .bin(wr_bin), .gray(wr_gray), .full(wr_full),
        .push(wr_push), .addr(wr_addr)
    );

    dmcx_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .sync_mode(sync_mode),
        .pop_req(rd_valid), .peer_gray(wr_gray_at_rd), .peer_bin(wr_bin),
        .bin(rd_bin), .gray(rd_gray), .empty(rd_empty), .addr(rd_addr)
    );

    dmcx_ram #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk(wr_clk), .we(wr_push), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/dmcx_fifo_chk.sv
// Property checker for dmcx_fifo, attached by bind below.
// Reads the true pointers of both sides to judge flags and pointer motion.
module dmcx_fifo_chk #(
    parameter int AW = 3
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        wr_rst_n,
    input logic        rd_rst_n,
    input logic        sync_mode,
    input logic        wr_valid,
    input logic        wr_full,
    input logic        rd_valid,
    input logic        rd_empty,
    input logic [AW:0] wr_bin,
    input logic [AW:0] rd_bin,
    input logic [AW:0] wr_gray,
    input logic [AW:0] rd_gray
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};
    logic [AW:0] occ;
    assign occ = wr_bin - rd_bin;

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        occ <= DEPTH_P); // R8
    AST_FULL_HELD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (occ == DEPTH_P) |-> wr_full); // R8
    AST_EMPTY_HELD: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (wr_bin == rd_bin) |-> rd_empty); // R8
    AST_WR_IGNORED: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (wr_valid && wr_full) |=> (wr_bin == $past(wr_bin))); // R4
    AST_RD_IGNORED: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (rd_valid && rd_empty) |=> (rd_bin == $past(rd_bin))); // R5
    AST_SYNC_NEXT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n || !sync_mode)
        (wr_valid && !wr_full) |=> !rd_empty); // R2
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R10
    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R10
endmodule

bind dmcx_fifo dmcx_fifo_chk #(.AW(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .sync_mode(sync_mode), .wr_valid(wr_valid), .wr_full(wr_full),
    .rd_valid(rd_valid), .rd_empty(rd_empty), .wr_bin(wr_bin), .rd_bin(rd_bin),
    .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/dmcx_fifo_bench.sv
// Bench: queue reference model, exact per cycle in synchronous mode,
// bound-checked on free-running clocks in asynchronous mode.
module dmcx_fifo_bench;
    localparam int DW    = 64;
    localparam int AW    = 3;
    localparam int DEPTH = 8;
    localparam int NW    = 200;

    logic clk  = 1'b0;
    logic aclk = 1'b0;
    int   ahalf = 17;
    always #10 clk = ~clk;
    always #(ahalf) aclk = ~aclk;

    logic          sync_mode = 1'b1;
    logic          rd_clk;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, rd_empty;

    assign rd_clk = sync_mode ? clk : aclk;

    dmcx_fifo u_dmcx_fifo (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_empty(rd_empty), .sync_mode(sync_mode)
    );

    logic [DW-1:0] q[$];
    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset both sides, set the mode during reset, end at a write-clock negedge.
    task automatic do_reset(input logic mode);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_valid = 1'b0; rd_valid = 1'b0;
        sync_mode = mode;
        q.delete();
        repeat (4) @(posedge aclk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        check(wr_full === 1'b0, "R1 full", 64'(wr_full), 64'd0);
        check(rd_empty === 1'b1, "R1 empty", 64'(rd_empty), 64'd1);
    endtask

    // One synchronous-mode cycle: drive, clock, update model, compare all outputs.
    task automatic sstep(input bit wv, input logic [DW-1:0] wd, input bit rv, input string req);
        bit wacc, racc;
        wr_valid = wv; wr_data = wd; rd_valid = rv;
        wacc = wv && (q.size() < DEPTH);
        racc = rv && (q.size() > 0);
        @(posedge clk);
        @(negedge clk);
        if (racc) void'(q.pop_front());
        if (wacc) q.push_back(wd);
        wr_valid = 1'b0; rd_valid = 1'b0;
        check(wr_full === (q.size() == DEPTH), {req, " full"}, 64'(wr_full),
              64'(q.size() == DEPTH));
        check(rd_empty === (q.size() == 0), {req, " empty"}, 64'(rd_empty),
              64'(q.size() == 0));
        if (q.size() > 0)
            check(rd_data === q[0], {req, " head"}, rd_data, q[0]);
    endtask

    function automatic logic [DW-1:0] pat(input int n);
        return {32'(n) ^ 32'h5A3C_0000, 32'(n * 7 + 3)};
    endfunction

    int got = 0;

    initial begin
        // ---------- synchronous mode ----------
        do_reset(1'b1);
        sstep(1'b0, '0, 1'b1, "R5 read-empty");
        sstep(1'b1, pat(1), 1'b0, "R2 next-cycle");
        sstep(1'b1, pat(2), 1'b1, "R7 both-mid");
        for (int i = 3; i <= 9; i++) sstep(1'b1, pat(i), 1'b0, "R3 fill");
        sstep(1'b1, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0, "R4 write-full");
        sstep(1'b1, 64'hBAD0_BAD0_BAD0_BAD0, 1'b1, "R7 both-full");
        for (int i = 0; i < DEPTH; i++) sstep(1'b0, '0, 1'b1, "R6 drain");
        sstep(1'b1, pat(50), 1'b1, "R7 both-empty");
        for (int i = 0; i < 300; i++)
            sstep(($urandom % 3) != 0, pat(100 + i), ($urandom % 2) != 0, "R6 mix");

        // ---------- asynchronous mode ----------
        do_reset(1'b0);
        fork
            begin : writer
                int  sent = 0;
                bit  acc;
                while (sent < NW) begin
                    @(negedge clk);
                    if (q.size() == DEPTH)
                        check(wr_full === 1'b1, "R8 full held", 64'(wr_full), 64'd1);
                    wr_valid = ($urandom % 4) != 0;
                    wr_data  = pat(1000 + sent);
                    acc = wr_valid && !wr_full;
                    @(posedge clk);
                    if (acc) begin
                        q.push_back(wr_data);
                        sent++;
                    end
                end
                @(negedge clk);
                wr_valid = 1'b0;
            end
            begin : reader
                bit racc;
                while (got < NW) begin
                    @(negedge aclk);
                    if (q.size() == 0)
                        check(rd_empty === 1'b1, "R8 empty held", 64'(rd_empty), 64'd1);
                    rd_valid = ($urandom % 3) != 0;
                    racc = rd_valid && !rd_empty;
                    if (racc) begin
                        if (q.size() > 0) check(rd_data === q[0], "R9 data", rd_data, q[0]);
                        else check(1'b0, "R8 empty held", 64'(rd_empty), 64'd1);
                    end
                    @(posedge aclk);
                    if (racc) begin
                        if (q.size() > 0) void'(q.pop_front());
                        got++;
                    end
                end
                rd_valid = 1'b0;
            end
            begin : retune
                #3000 ahalf = 7;
                #3000 ahalf = 23;
            end
        join
        check(got == NW, "R9 count", 64'(got), 64'(NW));
        repeat (8) @(negedge clk);
        check(rd_empty === 1'b1, "R8 end empty", 64'(rd_empty), 64'd1);
        check(wr_full === 1'b0, "R8 end full", 64'(wr_full), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule